// File: doc/BRIEF.md
# Receive Address Filter Unit

This block decides whether a received frame should be kept, based only on its 48-bit destination address. It combines two filters. The first is a table of sixteen exact-match slots, each with its own valid flag. The second is a 4096-bit multicast hash table, held as 128 words of 32 bits. A 12-bit hash is cut from the last two address bytes. Software picks one of four cut positions through a 2-bit mode field.

Software programs the block through a simple register port. A write lands in the next clock edge. A read returns its data one cycle after the request, with a strobe. The frame parser presents each destination address with a valid pulse. The block answers one cycle later with a result strobe and an accept bit.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, every slot valid flag, every hash word and the mode field are zero. With that state, no destination address is accepted, and every mapped register reads zero.
- R2: Slot k has two words. Its low word sits at register address 2k and its high word at 2k+1. The low word holds address bytes 0..3, with byte 0 in bits [7:0]. The high word holds byte 4 in bits [7:0], byte 5 in bits [15:8] and the valid flag in bit 31. When the high word is read back, bits [30:16] are zero.
- R3: The destination bus carries address byte i in bits [8i+7:8i]. A destination equal to the stored address of a valid slot 1..15 is accepted.
- R4: A slot whose valid flag is clear never matches. Writing zero to both of its words retires it.
- R5: Slot 0 holds the station's own address. It matches only when that stored address is a usable station address. An address is unusable if it is a group address (bit 0 of byte 0 set), the all-ones broadcast, or all zeros.
- R6: The mode field is at register address 256, bits [1:0]. The hash is formed from byte4 (b4) and byte5 (b5) as follows, then masked to 12 bits:
  - mode 0: (b4>>4)|(b5<<4)
  - mode 1: (b4>>3)|(b5<<5)
  - mode 2: (b4>>2)|(b5<<6)
  - mode 3: b4|(b5<<8)

  Hash bits [11:5] pick the hash word, which sits at register address 128 plus the word number. Hash bits [4:0] pick the bit inside that word.
- R7: A group destination that misses every slot is accepted exactly when its hash bit is set. An individual destination that misses every slot is rejected, whatever the hash table holds.
- R8: Timing:
  - A destination presented in cycle n produces exactly one result strobe, in cycle n+1.
  - A read request in cycle n produces exactly one read strobe, in cycle n+1.
  - Back-to-back presentations produce back-to-back results.
- R9: Writes to unmapped register addresses change nothing, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write request |
| reg_rd_i | input | 1 | Register read request |
| reg_addr_i | input | 9 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data strobe |
| da_valid_i | input | 1 | Destination address presented |
| da_i | input | 48 | Destination address, byte i in bits [8i+7:8i] |
| res_valid_o | output | 1 | Filter result strobe |
| res_accept_o | output | 1 | Frame accepted, valid with res_valid_o |

## Verification
Every internal state of this block shows up at the ports within one cycle, because it has no pipeline beyond the single result register.

A corrupted slot word or valid flag shows in two places:
- the readback of that word, one cycle after the read;
- the accept decision for a crafted address, one cycle after it is presented.

A wrong hash cut or word/bit split makes a group address with a chosen hash bit be rejected while another is accepted. Each mode is therefore exercised with the same address and a single set bit.

The station-address guard on slot 0 is visible only as a rejection of an address that a plain compare would have accepted.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;

    localparam int unsigned MAC_W  = 48;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HASH_W = 12;
    localparam int unsigned PAIR_W = 16;

    typedef logic [1:0] hmode_t;

    // Hash from the last two address bytes; the mode selects the right shift.
    function automatic logic [HASH_W-1:0] hash_of(input logic [MAC_W-1:0] da, input hmode_t m);
        logic [PAIR_W-1:0] pair;
        logic [PAIR_W-1:0] shifted;
        pair = da[MAC_W-1 -: PAIR_W];
        case (m)
            2'd0:    shifted = pair >> 4;
            2'd1:    shifted = pair >> 3;
            2'd2:    shifted = pair >> 2;
            default: shifted = pair;
        endcase
        return shifted[HASH_W-1:0];
    endfunction

    // Usable station address: individual, not broadcast, not zero.
    function automatic logic station_ok(input logic [MAC_W-1:0] a);
        return !a[0] && (a != {MAC_W{1'b1}}) && (a != {MAC_W{1'b0}});
    endfunction

endpackage

// File: rtl/rxf_exact_table.sv
`timescale 1ns/1ps
module rxf_exact_table
    import rxf_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 16,
    parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  logic                wr_hi_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    input  logic [IDX_W-1:0]    rd_idx_i,
    input  logic                rd_hi_i,
    output logic [WORD_W-1:0]   rd_word_o,
    input  logic [MAC_W-1:0]    look_da_i,
    output logic                hit_o
);
    localparam int unsigned HI_W    = MAC_W - WORD_W;
    localparam int unsigned VLD_BIT = WORD_W - 1;
    localparam int unsigned GAP_W   = WORD_W - HI_W - 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][WORD_W-1:0] lo;
        logic [NUM_SLOTS-1:0][HI_W-1:0]   hi;
        logic [NUM_SLOTS-1:0]             vld;
    } slot_state_t;

    slot_state_t st_d, st_q;
    logic [NUM_SLOTS-1:0] match_vec;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_hi_i) begin
                st_d.hi[wr_idx_i]  = wr_data_i[HI_W-1:0];
                st_d.vld[wr_idx_i] = wr_data_i[VLD_BIT];
            end else begin
                st_d.lo[wr_idx_i]  = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        logic [MAC_W-1:0] stored;
        assign stored = {st_q.hi[g], st_q.lo[g]};
        if (g == 0) begin : g_station
            assign match_vec[g] = st_q.vld[g] && station_ok(stored) && (stored == look_da_i);
        end else begin : g_plain
            assign match_vec[g] = st_q.vld[g] && (stored == look_da_i);
        end
    end

    assign hit_o     = |match_vec;
    assign rd_word_o = rd_hi_i ? {st_q.vld[rd_idx_i], {GAP_W{1'b0}}, st_q.hi[rd_idx_i]}
                               : st_q.lo[rd_idx_i];

    // R4
    entry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_hi_i && !wr_data_i[VLD_BIT]) |=> !st_q.vld[$past(wr_idx_i)]);

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (st_q.vld != '0));

endmodule

// File: rtl/rxf_hash_table.sv
`timescale 1ns/1ps
module rxf_hash_table
    import rxf_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 128,
    parameter int unsigned WIDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [WIDX_W-1:0]   wr_idx_i,
    input  logic [WORD_W-1:0]   wr_data_i,
    input  logic                mode_wr_i,
    input  hmode_t              mode_data_i,
    input  logic [WIDX_W-1:0]   rd_idx_i,
    output logic [WORD_W-1:0]   rd_word_o,
    output hmode_t              mode_o,
    input  logic [MAC_W-1:0]    look_da_i,
    output logic                bit_o
);
    localparam int unsigned BIT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        hmode_t                           mode;
    } hash_state_t;

    hash_state_t st_d, st_q;
    logic [HASH_W-1:0] hidx;
    logic [WIDX_W-1:0] word_sel;
    logic [BIT_W-1:0]  bit_sel;

    always_comb begin
        st_d = st_q;
        if (wr_en_i)   st_d.words[wr_idx_i] = wr_data_i;
        if (mode_wr_i) st_d.mode            = mode_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hidx      = hash_of(look_da_i, st_q.mode);
    assign word_sel  = hidx[BIT_W +: WIDX_W];
    assign bit_sel   = hidx[BIT_W-1:0];
    assign bit_o     = st_q.words[word_sel][bit_sel];
    assign rd_word_o = st_q.words[rd_idx_i];
    assign mode_o    = st_q.mode;

    // R6
    hash_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (st_q.words[$past(wr_idx_i)] == $past(wr_data_i)));

    // R6
    mode_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_wr_i |=> (mode_o == $past(mode_data_i)));

endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 16,
    parameter int unsigned NUM_WORDS = 128,
    parameter int unsigned ADDR_W    = 9
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                reg_rvalid_o,
    input  logic                da_valid_i,
    input  logic [47:0]         da_i,
    output logic                res_valid_o,
    output logic                res_accept_o
);
    localparam int unsigned IDX_W  = $clog2(NUM_SLOTS);
    localparam int unsigned WIDX_W = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] SLOT_END  = ADDR_W'(2 * NUM_SLOTS);
    localparam logic [ADDR_W-1:0] HASH_BASE = ADDR_W'(1 << (ADDR_W - 2));
    localparam logic [ADDR_W-1:0] HASH_END  = ADDR_W'((1 << (ADDR_W - 2)) + NUM_WORDS);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(1 << (ADDR_W - 1));

    typedef struct packed {
        logic              res_valid;
        logic              res_accept;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_data;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              in_slot, in_hash, in_mode;
    logic              ex_hit, hash_bit;
    logic [WORD_W-1:0] ex_rd, hash_rd;
    hmode_t            mode_now;

    assign in_slot = reg_addr_i < SLOT_END;
    assign in_hash = (reg_addr_i >= HASH_BASE) && (reg_addr_i < HASH_END);
    assign in_mode = reg_addr_i == MODE_ADDR;

    rxf_exact_table #(.NUM_SLOTS(NUM_SLOTS)) u_exact (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (reg_wr_i && in_slot),
        .wr_idx_i  (reg_addr_i[IDX_W:1]),
        .wr_hi_i   (reg_addr_i[0]),
        .wr_data_i (reg_wdata_i),
        .rd_idx_i  (reg_addr_i[IDX_W:1]),
        .rd_hi_i   (reg_addr_i[0]),
        .rd_word_o (ex_rd),
        .look_da_i (da_i),
        .hit_o     (ex_hit)
    );

    rxf_hash_table #(.NUM_WORDS(NUM_WORDS)) u_hash (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (reg_wr_i && in_hash),
        .wr_idx_i    (reg_addr_i[WIDX_W-1:0]),
        .wr_data_i   (reg_wdata_i),
        .mode_wr_i   (reg_wr_i && in_mode),
        .mode_data_i (reg_wdata_i[1:0]),
        .rd_idx_i    (reg_addr_i[WIDX_W-1:0]),
        .rd_word_o   (hash_rd),
        .mode_o      (mode_now),
        .look_da_i   (da_i),
        .bit_o       (hash_bit)
    );

    always_comb begin
        st_d            = st_q;
        st_d.res_valid  = da_valid_i;
        st_d.res_accept = da_valid_i && (ex_hit || (da_i[0] && hash_bit));
        st_d.rd_valid   = reg_rd_i;
        st_d.rd_data    = '0;
        if (reg_rd_i) begin
            if (in_slot)      st_d.rd_data = ex_rd;
            else if (in_hash) st_d.rd_data = hash_rd;
            else if (in_mode) st_d.rd_data = {{(WORD_W-2){1'b0}}, mode_now};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign res_valid_o  = st_q.res_valid;
    assign res_accept_o = st_q.res_accept;
    assign reg_rvalid_o = st_q.rd_valid;
    assign reg_rdata_o  = st_q.rd_data;

    // R8
    res_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        da_valid_i |=> res_valid_o);

    // R8
    res_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !da_valid_i |=> !res_valid_o);

    // R8
    rd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rd_i |=> reg_rvalid_o);

    // R7
    unicast_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (da_valid_i && !da_i[0] && !ex_hit) |=> !res_accept_o);

endmodule

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, res_accept;

    always #5 clk = ~clk;

    rx_addr_filter dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .reg_rvalid_o(reg_rvalid),
        .da_valid_i(da_valid), .da_i(da),
        .res_valid_o(res_valid), .res_accept_o(res_accept)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { logic [31:0] exp; string req; } exp_t;
    exp_t res_q[$];
    exp_t rd_q[$];

    // Reference model state
    logic [31:0] m_lo [16];
    logic [31:0] m_hi [16];
    logic [31:0] m_hash [128];
    logic [1:0]  m_mode;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] m_hidx(input logic [47:0] a, input logic [1:0] m);
        int b4, b5, h;
        b4 = int'(a[39:32]);
        b5 = int'(a[47:40]);
        case (m)
            2'd0: h = (b4 >> 4) | (b5 << 4);
            2'd1: h = (b4 >> 3) | (b5 << 5);
            2'd2: h = (b4 >> 2) | (b5 << 6);
            default: h = b4 | (b5 << 8);
        endcase
        return 12'(h & 32'hFFF);
    endfunction

    function automatic logic m_accept(input logic [47:0] a);
        logic [11:0] h;
        for (int i = 0; i < 16; i++) begin
            logic [47:0] s;
            s = {m_hi[i][15:0], m_lo[i]};
            if (m_hi[i][31] && s == a) begin
                if (i != 0) return 1'b1;
                if (s[0] == 1'b0 && s != 48'hFFFF_FFFF_FFFF && s != 48'h0) return 1'b1;
            end
        end
        if (!a[0]) return 1'b0;
        h = m_hidx(a, m_mode);
        return m_hash[h[11:5]][h[4:0]];
    endfunction

    function automatic logic [31:0] m_read(input logic [8:0] ad);
        if (ad < 9'd32) return ad[0] ? (m_hi[ad[4:1]] & 32'h8000_FFFF) : m_lo[ad[4:1]];
        if (ad >= 9'd128 && ad < 9'd256) return m_hash[ad[6:0]];
        if (ad == 9'd256) return {30'b0, m_mode};
        return 32'h0;
    endfunction

    task automatic reg_write(input logic [8:0] ad, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
        if (ad < 9'd32) begin
            if (ad[0]) m_hi[ad[4:1]] = d; else m_lo[ad[4:1]] = d;
        end else if (ad >= 9'd128 && ad < 9'd256) m_hash[ad[6:0]] = d;
        else if (ad == 9'd256) m_mode = d[1:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [8:0] ad, input string req);
        exp_t e;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ad;
        e.exp = m_read(ad); e.req = req;
        rd_q.push_back(e);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic present(input logic [47:0] a, input string req);
        exp_t e;
        @(negedge clk);
        da_valid = 1'b1; da = a;
        e.exp = {31'b0, m_accept(a)}; e.req = req;
        res_q.push_back(e);
        @(negedge clk);
        da_valid = 1'b0;
    endtask

    task automatic present_pair(input logic [47:0] a, input logic [47:0] b, input string req);
        exp_t e;
        @(negedge clk);
        da_valid = 1'b1; da = a;
        e.exp = {31'b0, m_accept(a)}; e.req = req;
        res_q.push_back(e);
        @(negedge clk);
        da = b;
        e.exp = {31'b0, m_accept(b)};
        res_q.push_back(e);
        @(negedge clk);
        da_valid = 1'b0;
    endtask

    task automatic set_slot(input int k, input logic [47:0] a, input logic v);
        reg_write(9'(2*k), a[31:0]);
        reg_write(9'(2*k+1), {v, 15'b0, a[47:32]});
    endtask

    task automatic set_hash_bit(input logic [47:0] a);
        logic [11:0] h;
        h = m_hidx(a, m_mode);
        reg_write(9'(128 + int'(h[11:5])), m_hash[h[11:5]] | (32'h1 << h[4:0]));
    endtask

    // Monitor: pops expected items as strobes appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                if (res_q.size() == 0) check(1'b0, "R8 unexpected result strobe", 32'h1, 32'h0);
                else begin
                    exp_t e;
                    e = res_q.pop_front();
                    check(res_accept == e.exp[0], e.req, {31'b0, res_accept}, e.exp);
                end
            end
            if (reg_rvalid) begin
                if (rd_q.size() == 0) check(1'b0, "R8 unexpected read strobe", 32'h1, 32'h0);
                else begin
                    exp_t e;
                    e = rd_q.pop_front();
                    check(reg_rdata == e.exp, e.req, reg_rdata, e.exp);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [47:0] A3  = 48'h55_44_33_22_11_02; // 02:11:22:33:44:55
    localparam logic [47:0] STN = 48'hEE_DD_CC_BB_AA_00;
    localparam logic [47:0] MC  = 48'h34_12_00_5E_00_01; // 01:00:5E:00:12:34

    initial begin
        for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        for (int i = 0; i < 128; i++) m_hash[i] = '0;
        m_mode = 2'd0;

        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(res_valid == 1'b0 && reg_rvalid == 1'b0, "R1 reset strobes", {30'b0, res_valid, reg_rvalid}, 32'h0);
        rst_n = 1'b1;

        // R1: cleared state
        reg_read(9'd1, "R1 slot hi reads zero");
        reg_read(9'd130, "R1 hash word reads zero");
        reg_read(9'd256, "R1 mode reads zero");
        present(48'h0, "R1 zero address rejected");
        present(48'hFFFF_FFFF_FFFF, "R1 broadcast rejected");
        present(MC, "R1 group address rejected");

        // R3, R2
        set_slot(3, A3, 1'b1);
        present(A3, "R3 exact hit slot 3");
        present(A3 ^ 48'h01_00_00_00_00_00, "R3 byte5 differs rejected");
        reg_read(9'd6, "R2 low word layout");
        reg_read(9'd7, "R2 high word layout");
        check(m_read(9'd6) == 32'h3322_1102 && m_read(9'd7) == 32'h8000_5544, "R2 model layout", m_read(9'd7), 32'h8000_5544);
        reg_write(9'd15, 32'hFFFF_FFFF);
        reg_read(9'd15, "R2 high word gap bits read zero");

        // R4
        set_slot(9, 48'h0A_0B_0C_0D_0E_10, 1'b0);
        present(48'h0A_0B_0C_0D_0E_10, "R4 invalid slot does not match");
        set_slot(3, 48'h0, 1'b0);
        present(A3, "R4 cleared slot rejected");

        // R5
        set_slot(0, STN, 1'b1);
        present(STN, "R5 station address accepted");
        set_slot(0, MC, 1'b1);
        present(MC, "R5 group station address not matched");
        set_slot(0, 48'h0, 1'b1);
        present(48'h0, "R5 zero station address not matched");
        set_slot(0, 48'hFFFF_FFFF_FFFF, 1'b1);
        present(48'hFFFF_FFFF_FFFF, "R5 broadcast station address not matched");

        // R6, R7: one bit per mode
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 128; w += 1) if (m_hash[w] != 0) reg_write(9'(128 + w), 32'h0);
            reg_write(9'd256, 32'(m));
            reg_read(9'd256, "R6 mode readback");
            present(MC, "R7 group miss with clear bit rejected");
            set_hash_bit(MC);
            present(MC, "R6 hash bit selects group address");
            present(MC ^ 48'h00_00_00_00_00_01, "R7 individual miss rejected despite hash bit");
            reg_write(9'd256, 32'((m + 1) % 4));
            present(MC, "R6 other mode uses other bit");
        end
        reg_read(9'(128 + int'(m_hidx(MC, 2'd3) >> 5)), "R6 hash word readback");

        // R9
        reg_write(9'd384, 32'hDEAD_BEEF);
        reg_read(9'd384, "R9 unmapped read zero");
        reg_read(9'd40, "R9 gap read zero");
        present(MC, "R9 unmapped write no effect");

        // R8 back to back
        set_slot(5, A3, 1'b1);
        present_pair(A3, STN, "R8 back-to-back results");
        present_pair(48'h0, A3, "R8 back-to-back results second");

        repeat (4) @(negedge clk);
        done = 1;
        check(res_q.size() == 0, "R8 every presentation answered", res_q.size(), 0);
        check(rd_q.size() == 0, "R8 every read answered", rd_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule